// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block is a small bank of waiting slots placed in front of one execution unit of an out-of-order core. When the issue stage hands it an instruction, a free slot records the operation code, the reorder-buffer tag the result will carry, and, for each of the two sources, either the value itself or the tag of the instruction that will produce it. Slots watch the shared result bus. When a broadcast tag matches a missing source, the slot takes the broadcast value. That operand counts as present from the next cycle onward.

Each cycle the pool sends at most one instruction whose operands are all present to its unit. When several are ready, it picks the one issued earliest. The unit is modelled as a delay line of parameter length. It returns the tag, the operation and both operand values. It can accept a new instruction every cycle (pipelined) or only once the previous one has run its full latency (blocking). A `full` flag lets the issue stage stall. Typical settings are 2 slots with 1 cycle for integer work, 3 slots with 4 cycles for floating-point add, and 2 slots with 8 cycles for multiply.

Top module: `rsv_pool`

## Requirements
- R1: After reset, `full` is low and `resValid` is low.
- R2: An instruction issued in cycle t with both sources present is dispatched in cycle t+1, and its result appears on the output in cycle t+1+LATENCY.
- R3: A source waiting on tag X that sees X on the bus in cycle b counts as present from cycle b+1. If the instruction is then ready and chosen, its result appears in cycle b+1+LATENCY.
- R4: If the bus broadcasts a tag in the same cycle that an instruction waiting on that tag is issued, the instruction captures the value and behaves as in R3.
- R5: When several slots are ready in the same cycle, the pool dispatches the one issued earliest, whatever slot index it sits in.
- R6: `full` is high exactly when every slot is occupied. An issue request while `full` is high is dropped and never yields a result.
- R7: With PIPELINED=0, two dispatches are at least LATENCY cycles apart.
- R8: With PIPELINED=1, ready instructions dispatch in consecutive cycles, so their results come out in consecutive cycles.
- R9: A result carries the instruction's destination tag and operation code, along with operand values. Each operand value is either the one given at issue or the one captured from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issueValid | input | 1 | Issue request this cycle |
| issueOp | input | OP_W | Operation code |
| issueTag | input | TAG_W | Destination reorder-buffer tag |
| src1Ready | input | 1 | Source 1 value is present |
| src1Val | input | DATA_W | Source 1 value |
| src1Tag | input | TAG_W | Source 1 producer tag |
| src2Ready | input | 1 | Source 2 value is present |
| src2Val | input | DATA_W | Source 2 value |
| src2Tag | input | TAG_W | Source 2 producer tag |
| busValid | input | 1 | Result bus broadcast valid |
| busTag | input | TAG_W | Broadcast tag |
| busVal | input | DATA_W | Broadcast value |
| full | output | 1 | All slots occupied |
| resValid | output | 1 | Unit result valid |
| resTag | output | TAG_W | Result destination tag |
| resOp | output | OP_W | Result operation code |
| resA | output | DATA_W | Operand 1 as executed |
| resB | output | DATA_W | Operand 2 as executed |

## Verification
The hardest situation to reach is age-ordered selection where the older instruction sits in the higher slot index. This happens only after a slot has been freed and then refilled by a younger instruction. The stimulus first issues a ready instruction so it drains from slot 0. It then issues two instructions that wait on the same tag, so the younger one lands in slot 0. A single broadcast then wakes both in the same cycle. The pool is also filled to capacity with a further request dropped, and a blocking-mode copy receives two back-to-back ready instructions so the forced gap becomes visible.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int MAX_ST = 8;
  localparam int IDX_W  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic             issueEn;
    logic             dispEn;
    logic [IDX_W-1:0] allocIdx;
    logic [IDX_W-1:0] dispIdx;
  } rsv_strb_t;
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int NUM_ST    = 3,
  parameter int LATENCY   = 4,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [NUM_ST-1:0] validVec,
  input  logic [NUM_ST-1:0] readyVec,
  output rsv_strb_t         strb,
  output logic              full
);
  localparam int AGE_W = $clog2(NUM_ST + 1);
  localparam int GAP_W = $clog2(LATENCY + 1);

  // age = number of younger occupied slots
  logic [AGE_W-1:0] age [NUM_ST];
  logic             canDisp;
  logic             found;
  logic [AGE_W-1:0] bestAge;
  logic [AGE_W-1:0] dispAge;

  always_comb begin
    full          = &validVec;
    strb.issueEn  = issueValid && !full;
    strb.allocIdx = '0;
    for (int i = NUM_ST - 1; i >= 0; i--)
      if (!validVec[i]) strb.allocIdx = IDX_W'(i);
    found        = 1'b0;
    bestAge      = '0;
    strb.dispIdx = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (readyVec[i] && (!found || age[i] > bestAge)) begin
        found        = 1'b1;
        bestAge      = age[i];
        strb.dispIdx = IDX_W'(i);
      end
    end
    strb.dispEn = found && canDisp;
    dispAge     = bestAge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ST; i++) age[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ST; i++) begin
        if (strb.issueEn && strb.allocIdx == IDX_W'(i))
          age[i] <= '0;
        else if (validVec[i] && !(strb.dispEn && strb.dispIdx == IDX_W'(i)))
          age[i] <= age[i] + AGE_W'(strb.issueEn)
                    - AGE_W'(strb.dispEn && age[i] > dispAge);
      end
    end
  end

  if (PIPELINED) begin : gPipe
    assign canDisp = 1'b1;
  end else begin : gBlock
    logic [GAP_W-1:0] gapCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               gapCnt <= '0;
      else if (strb.dispEn)     gapCnt <= GAP_W'(LATENCY - 1);
      else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
    end
    assign canDisp = (gapCnt == '0);

    if (LATENCY > 1) begin : gGapChk
      assert_block_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strb.dispEn |=> !strb.dispEn);
    end
  end

  initial begin
    assert_slot_limit: assert (NUM_ST >= 2 && NUM_ST <= MAX_ST);
  end
endmodule

// File: rtl/rsv_data.sv
module rsv_data
  import rsv_pkg::*;
#(
  parameter int NUM_ST  = 3,
  parameter int LATENCY = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int OP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rsv_strb_t         strb,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              src1Ready,
  input  logic [DATA_W-1:0] src1Val,
  input  logic [TAG_W-1:0]  src1Tag,
  input  logic              src2Ready,
  input  logic [DATA_W-1:0] src2Val,
  input  logic [TAG_W-1:0]  src2Tag,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busVal,
  output logic [NUM_ST-1:0] validVec,
  output logic [NUM_ST-1:0] readyVec,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [OP_W-1:0]   resOp,
  output logic [DATA_W-1:0] resA,
  output logic [DATA_W-1:0] resB
);
  logic [NUM_ST-1:0] rdyA, rdyB, dispHit;
  logic [OP_W-1:0]   stOp   [NUM_ST];
  logic [TAG_W-1:0]  stTag  [NUM_ST];
  logic [TAG_W-1:0]  waitA  [NUM_ST];
  logic [TAG_W-1:0]  waitB  [NUM_ST];
  logic [DATA_W-1:0] valA   [NUM_ST];
  logic [DATA_W-1:0] valB   [NUM_ST];

  logic              hit1, hit2;
  logic [OP_W-1:0]   dOp;
  logic [TAG_W-1:0]  dTag;
  logic [DATA_W-1:0] dA, dB;

  assign hit1     = busValid && busTag == src1Tag;
  assign hit2     = busValid && busTag == src2Tag;
  assign readyVec = validVec & rdyA & rdyB;

  always_comb begin
    dOp = '0; dTag = '0; dA = '0; dB = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      dispHit[i] = strb.dispEn && strb.dispIdx == IDX_W'(i);
      if (dispHit[i]) begin
        dOp = stOp[i]; dTag = stTag[i]; dA = valA[i]; dB = valB[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0; rdyA <= '0; rdyB <= '0;
      for (int i = 0; i < NUM_ST; i++) begin
        stOp[i] <= '0; stTag[i] <= '0; waitA[i] <= '0; waitB[i] <= '0;
        valA[i] <= '0; valB[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ST; i++) begin
        if (strb.issueEn && strb.allocIdx == IDX_W'(i)) begin
          validVec[i] <= 1'b1;
          stOp[i]     <= issueOp;
          stTag[i]    <= issueTag;
          waitA[i]    <= src1Tag;
          waitB[i]    <= src2Tag;
          rdyA[i]     <= src1Ready || hit1;
          rdyB[i]     <= src2Ready || hit2;
          valA[i]     <= src1Ready ? src1Val : busVal;
          valB[i]     <= src2Ready ? src2Val : busVal;
        end else begin
          if (dispHit[i]) validVec[i] <= 1'b0;
          if (validVec[i] && !rdyA[i] && busValid && busTag == waitA[i]) begin
            rdyA[i] <= 1'b1; valA[i] <= busVal;
          end
          if (validVec[i] && !rdyB[i] && busValid && busTag == waitB[i]) begin
            rdyB[i] <= 1'b1; valB[i] <= busVal;
          end
        end
      end
    end
  end

  // fixed-latency unit model
  logic [LATENCY-1:0] pV;
  logic [OP_W-1:0]    pOp  [LATENCY];
  logic [TAG_W-1:0]   pTag [LATENCY];
  logic [DATA_W-1:0]  pA   [LATENCY];
  logic [DATA_W-1:0]  pB   [LATENCY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pV <= '0;
      for (int k = 0; k < LATENCY; k++) begin
        pOp[k] <= '0; pTag[k] <= '0; pA[k] <= '0; pB[k] <= '0;
      end
    end else begin
      pV[0] <= strb.dispEn; pOp[0] <= dOp; pTag[0] <= dTag;
      pA[0] <= dA;          pB[0]  <= dB;
      for (int k = 1; k < LATENCY; k++) begin
        pV[k] <= pV[k-1]; pOp[k] <= pOp[k-1]; pTag[k] <= pTag[k-1];
        pA[k] <= pA[k-1]; pB[k]  <= pB[k-1];
      end
    end
  end

  assign resValid = pV[LATENCY-1];
  assign resOp    = pOp[LATENCY-1];
  assign resTag   = pTag[LATENCY-1];
  assign resA     = pA[LATENCY-1];
  assign resB     = pB[LATENCY-1];

  assert_disp_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dispEn |-> (dispHit & readyVec) != '0);

  assert_full_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&validVec) |=> $countones(validVec) >= NUM_ST - 1);

  for (genvar g = 0; g < NUM_ST; g++) begin : gWake
    assert_wake_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (validVec[g] && !rdyA[g] && busValid && busTag == waitA[g]) |=> rdyA[g]);
    assert_issue_catch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.issueEn && strb.allocIdx == IDX_W'(g) && hit1) |=> rdyA[g]);
  end
endmodule

// File: rtl/rsv_pool.sv
module rsv_pool
  import rsv_pkg::*;
#(
  parameter int NUM_ST    = 3,
  parameter int LATENCY   = 4,
  parameter bit PIPELINED = 1'b1,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int OP_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              src1Ready,
  input  logic [DATA_W-1:0] src1Val,
  input  logic [TAG_W-1:0]  src1Tag,
  input  logic              src2Ready,
  input  logic [DATA_W-1:0] src2Val,
  input  logic [TAG_W-1:0]  src2Tag,
  input  logic              busValid,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [DATA_W-1:0] busVal,
  output logic              full,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [OP_W-1:0]   resOp,
  output logic [DATA_W-1:0] resA,
  output logic [DATA_W-1:0] resB
);
  rsv_strb_t         strb;
  logic [NUM_ST-1:0] validVec, readyVec;

  rsv_ctrl #(.NUM_ST(NUM_ST), .LATENCY(LATENCY), .PIPELINED(PIPELINED)) uCtrl (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid),
    .validVec(validVec), .readyVec(readyVec), .strb(strb), .full(full)
  );

  rsv_data #(.NUM_ST(NUM_ST), .LATENCY(LATENCY), .DATA_W(DATA_W),
             .TAG_W(TAG_W), .OP_W(OP_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .issueOp(issueOp), .issueTag(issueTag),
    .src1Ready(src1Ready), .src1Val(src1Val), .src1Tag(src1Tag),
    .src2Ready(src2Ready), .src2Val(src2Val), .src2Tag(src2Tag),
    .busValid(busValid), .busTag(busTag), .busVal(busVal),
    .validVec(validVec), .readyVec(readyVec),
    .resValid(resValid), .resTag(resTag), .resOp(resOp), .resA(resA), .resB(resB)
  );
endmodule

// File: tb/sim_rsv_pool.sv
module sim_rsv_pool;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        iv0 = 0, iv1 = 0, r1 = 0, r2 = 0, bv = 0;
  logic [3:0]  op = 0, tg = 0, t1 = 0, t2 = 0, bt = 0;
  logic [15:0] v1 = 0, v2 = 0, bval = 0;
  logic        full0, rv0, full1, rv1;
  logic [3:0]  rtag0, rop0, rtag1, rop1;
  logic [15:0] ra0, rb0, ra1, rb1;

  rsv_pool #(.NUM_ST(3), .LATENCY(4), .PIPELINED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .issueValid(iv0), .issueOp(op), .issueTag(tg),
    .src1Ready(r1), .src1Val(v1), .src1Tag(t1), .src2Ready(r2), .src2Val(v2), .src2Tag(t2),
    .busValid(bv), .busTag(bt), .busVal(bval), .full(full0),
    .resValid(rv0), .resTag(rtag0), .resOp(rop0), .resA(ra0), .resB(rb0));

  rsv_pool #(.NUM_ST(2), .LATENCY(3), .PIPELINED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .issueValid(iv1), .issueOp(op), .issueTag(tg),
    .src1Ready(r1), .src1Val(v1), .src1Tag(t1), .src2Ready(r2), .src2Val(v2), .src2Tag(t2),
    .busValid(bv), .busTag(bt), .busVal(bval), .full(full1),
    .resValid(rv1), .resTag(rtag1), .resOp(rop1), .resA(ra1), .resB(rb1));

  typedef struct {
    logic [3:0]  tag;
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    int          cyc;
    string       req;
  } exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor on u0
  always @(negedge clk) begin
    if (rst_n && rv0) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected result tag", int'(rtag0), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rtag0 == e.tag, {e.req, " tag"}, int'(rtag0), int'(e.tag));
        chk(cyc == e.cyc, {e.req, " cycle"}, cyc, e.cyc);
        chk(rop0 == e.op && ra0 == e.a && rb0 == e.b, {e.req, " R9 payload"},
            int'(ra0), int'(e.a));
      end
    end
  end

  task automatic clr();
    iv0 = 0; iv1 = 0; bv = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask

  task automatic issue(input bit toU1, input logic [3:0] itag, input logic [3:0] iop,
                       input bit rd1, input logic [15:0] a, input logic [3:0] wt1,
                       input bit rd2, input logic [15:0] b, input logic [3:0] wt2);
    @(negedge clk); clr();
    iv0 = !toU1; iv1 = toU1; tg = itag; op = iop;
    r1 = rd1; v1 = a; t1 = wt1; r2 = rd2; v2 = b; t2 = wt2;
  endtask

  task automatic bus(input logic [3:0] btag, input logic [15:0] bvalue);
    @(negedge clk); clr();
    bv = 1; bt = btag; bval = bvalue;
  endtask

  task automatic push(input logic [3:0] etag, input logic [3:0] eop,
                      input logic [15:0] a, input logic [15:0] b,
                      input int c, input string req);
    exp_t e;
    e.tag = etag; e.op = eop; e.a = a; e.b = b; e.cyc = c; e.req = req;
    q.push_back(e);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int m;
    int n;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(full0 == 0, "R1 full", int'(full0), 0);
    chk(rv0 == 0, "R1 resValid", int'(rv0), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: ready at issue
    issue(0, 4'd1, 4'd3, 1, 16'd10, 0, 1, 16'd20, 0);
    push(4'd1, 4'd3, 16'd10, 16'd20, cyc + 5, "R2");
    idle(10);

    // R3: wait on tag 9, broadcast later
    issue(0, 4'd2, 4'd4, 0, 16'd0, 4'd9, 1, 16'd7, 0);
    idle(3);
    bus(4'd9, 16'd55);
    push(4'd2, 4'd4, 16'd55, 16'd7, cyc + 5, "R3");
    idle(10);

    // R4: broadcast in the issue cycle
    issue(0, 4'd3, 4'd5, 0, 16'd0, 4'd10, 1, 16'd9, 0);
    bv = 1; bt = 4'd10; bval = 16'd66;
    push(4'd3, 4'd5, 16'd66, 16'd9, cyc + 5, "R4");
    idle(10);

    // R5: older instruction in higher slot index
    issue(0, 4'd4, 4'd1, 1, 16'd1, 0, 1, 16'd2, 0);
    push(4'd4, 4'd1, 16'd1, 16'd2, cyc + 5, "R5 filler");
    issue(0, 4'd5, 4'd2, 0, 16'd0, 4'd11, 1, 16'd3, 0);
    idle(2);
    issue(0, 4'd6, 4'd6, 0, 16'd0, 4'd11, 1, 16'd4, 0);
    idle(1);
    bus(4'd11, 16'd77);
    push(4'd5, 4'd2, 16'd77, 16'd3, cyc + 5, "R5 older first");
    push(4'd6, 4'd6, 16'd77, 16'd4, cyc + 6, "R5 younger second");
    idle(12);

    // R6 and R8: fill, drop an extra issue, drain back to back
    issue(0, 4'd7, 4'd7, 0, 16'd0, 4'd13, 1, 16'd10, 0);
    issue(0, 4'd8, 4'd7, 0, 16'd0, 4'd13, 1, 16'd11, 0);
    issue(0, 4'd9, 4'd7, 0, 16'd0, 4'd13, 1, 16'd12, 0);
    issue(0, 4'd12, 4'd8, 1, 16'd99, 0, 1, 16'd98, 0);
    chk(full0 == 1, "R6 full when occupied", int'(full0), 1);
    idle(2);
    chk(full0 == 1, "R6 full after dropped issue", int'(full0), 1);
    bus(4'd13, 16'd88);
    m = cyc;
    push(4'd7, 4'd7, 16'd88, 16'd10, m + 5, "R8 first");
    push(4'd8, 4'd7, 16'd88, 16'd11, m + 6, "R8 second");
    push(4'd9, 4'd7, 16'd88, 16'd12, m + 7, "R8 third");
    idle(3);
    chk(full0 == 0, "R6 full released", int'(full0), 0);
    idle(12);
    chk(q.size() == 0, "R6 R9 all results seen", q.size(), 0);

    // R7: blocking unit spaces dispatches by LATENCY=3
    issue(1, 4'd1, 4'd2, 1, 16'd5, 0, 1, 16'd6, 0);
    n = cyc;
    issue(1, 4'd2, 4'd2, 1, 16'd7, 0, 1, 16'd8, 0);
    for (int k = 2; k <= 9; k++) begin
      @(negedge clk); clr();
      chk(rv1 == ((k == 4) || (k == 7)), "R7 blocking result timing", int'(rv1),
          int'((k == 4) || (k == 7)));
      if (k == 4) chk(rtag1 == 4'd1, "R7 first tag", int'(rtag1), 1);
      if (k == 7) chk(rtag1 == 4'd2, "R7 second tag", int'(rtag1), 2);
    end
    chk(cyc == n + 9, "R7 cycle alignment", cyc, n + 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule